// File: doc/BRIEF.md
# Shadow-Loaded PWM Generator with Dead-Band Delay

This block produces a pulse-width modulated waveform from a 10-bit time base. A prescaler divides the input clock by 1, 4 or 16. Each divided tick advances a 2-bit fine count. Each wrap of the fine count advances an 8-bit coarse counter. When the coarse counter equals the period setting and the fine count is at its top value, the next tick starts a new cycle. At that moment the time base returns to zero, the waveform goes active, and every buffered setting becomes live. The waveform returns inactive when the whole 10-bit time base reaches the live duty value. A dead-band delay holds back the active edge by a programmable number of input clocks. Up to four pins carry the waveform, and each pin has its own polarity and its own steering bit.

Software changes settings through a write port. A period, duty, enable, polarity or steering write only fills a shadow register, and the live copy changes at the next period boundary. The output therefore never shows a cut-short or doubled pulse. The dead-band value uses a separate rule. It becomes live at the first duty match or period boundary after it is written, whichever comes first.

The write port uses a valid/ready handshake. `wr_ready` is always high, so a write is accepted in every cycle where `wr_valid` is high and the port never applies back-pressure. Register addresses: 0 = period (8 bits); 1 = duty bits 9..2; 2 = control, where bits 1..0 are duty bits 1..0 and bit 2 is enable; 3 = pin config, where bits 3..0 are polarity (1 = active-low) and bits 7..4 are steering; 4 = dead-band, bits 6..0. The prescale select `presc_sel` is a plain input: 0 selects divide-by-1, 1 selects divide-by-4, and 2 or 3 select divide-by-16.

Top module: `dbuf_pwm`

## Requirements
- R1: After reset, every pin sits at level 0, the period setting is 255, duty is 0, the generator is disabled, polarity is 0, only pin 0 is steered, and the dead-band is 0.
- R2: One PWM cycle lasts (period + 1) x 4 x D input clocks, where D is 1, 4 or 16 as chosen by `presc_sel` (0 gives 1, 1 gives 4, 2 and 3 give 16).
- R3: With a live duty value N that is neither 0 nor too large to be reached, the raw waveform is active for N x D input clocks from the start of each cycle.
- R4: A live duty value of 0 keeps the waveform inactive for the whole cycle, including the cycle start.
- R5: A live duty value larger than (period x 4 + 3) keeps the waveform active for the whole cycle, with no inactive edge.
- R6: Writes to period, duty, control and pin config do not alter the output until the next period boundary.
- R7: After the enable bit is written, the pins stay inactive until the first period boundary, and the first pulse starts there.
- R8: A pin with its polarity bit set drives the inverse of the waveform; its inactive level is 1.
- R9: A pin whose steering bit is clear holds its inactive level, which equals its polarity bit.
- R10: The active edge at the pins comes K input clocks after the raw waveform goes active, where K is the live dead-band value; the inactive edge is not delayed.
- R11: A written dead-band value becomes live at the first duty match or period boundary that follows the write.
- R12: `wr_ready` is always 1, and every cycle with `wr_valid` high performs one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| presc_sel | input | 2 | Time-base prescale select |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| pwm_out | output | 4 | Output pins |

## Verification
The assertions check on every cycle that the coarse count stays within the live period. They also check that the live settings change only in the cycle after a period boundary, and that the dead-band value changes only after a boundary or a duty match. Further per-cycle checks cover the following: a zero duty keeps the raw waveform inactive, an unreachable duty keeps it active, and unsteered pins sit at their polarity level. Three properties can only be shown by the bench's scenarios: the exact length of a cycle under each prescale, the active time, and the dead-band shortening of the pulse. The same holds for the wait after enabling and the cycle in which a mid-cycle write first appears at the pins.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;
  localparam int PS_W = 5;

  typedef enum logic [2:0] {
    REG_PERIOD   = 3'd0,
    REG_DUTY_HI  = 3'd1,
    REG_CTRL     = 3'd2,
    REG_PINCFG   = 3'd3,
    REG_DEADBAND = 3'd4
  } reg_addr_e;

  function automatic logic [PS_W-1:0] presc_div(input logic [1:0] sel);
    case (sel)
      2'd0:    presc_div = PS_W'(1);
      2'd1:    presc_div = PS_W'(4);
      default: presc_div = PS_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import dbpwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FINE_W = 2,
  localparam int TB_W  = CNT_W + FINE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       presc_sel,
  input  logic [CNT_W-1:0] per_act,
  input  logic [TB_W-1:0]  duty_act,
  output logic             wrap,
  output logic             match,
  output logic [TB_W-1:0]  tb
);
  logic [PS_W-1:0] pc_q;
  logic [PS_W-1:0] div;
  logic            tick;
  logic [TB_W-1:0] tb_q, tb_nx;

  assign div  = presc_div(presc_sel);
  assign tick = (pc_q >= div - PS_W'(1));
  assign wrap = tick && (tb_q[FINE_W-1:0] == {FINE_W{1'b1}})
                     && (tb_q[TB_W-1:FINE_W] == per_act);

  always_comb begin
    if (wrap)      tb_nx = '0;
    else if (tick) tb_nx = tb_q + TB_W'(1);
    else           tb_nx = tb_q;
  end

  assign match = tick && !wrap && (tb_nx == duty_act);
  assign tb    = tb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      tb_q <= '0;
    end else begin
      pc_q <= tick ? '0 : pc_q + PS_W'(1);
      tb_q <= tb_nx;
    end
  end
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import dbpwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FINE_W = 2,
  parameter int DB_W   = 7,
  parameter int NOUT   = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int TB_W  = CNT_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wrap,
  input  logic              match,
  output logic [CNT_W-1:0]  per_act,
  output logic [TB_W-1:0]   duty_act,
  output logic [TB_W-1:0]   duty_buf,
  output logic              en_buf,
  output logic [NOUT-1:0]   pol_act,
  output logic [NOUT-1:0]   steer_act,
  output logic [DB_W-1:0]   db_act
);
  logic [CNT_W-1:0] per_buf;
  logic [NOUT-1:0]  pol_buf, steer_buf;
  logic [DB_W-1:0]  db_buf;
  logic             db_pend;
  logic             db_load;

  assign db_load = db_pend && (wrap || match);

  // shadow side: written by the port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_buf   <= '1;
      duty_buf  <= '0;
      en_buf    <= 1'b0;
      pol_buf   <= '0;
      steer_buf <= NOUT'(1);
      db_buf    <= '0;
    end else if (wr_fire) begin
      case (wr_addr)
        ADDR_W'(REG_PERIOD):   per_buf <= wr_data[CNT_W-1:0];
        ADDR_W'(REG_DUTY_HI):  duty_buf[TB_W-1:FINE_W] <= wr_data[CNT_W-1:0];
        ADDR_W'(REG_CTRL): begin
          duty_buf[FINE_W-1:0] <= wr_data[FINE_W-1:0];
          en_buf               <= wr_data[FINE_W];
        end
        ADDR_W'(REG_PINCFG): begin
          pol_buf   <= wr_data[NOUT-1:0];
          steer_buf <= wr_data[2*NOUT-1:NOUT];
        end
        ADDR_W'(REG_DEADBAND): db_buf <= wr_data[DB_W-1:0];
        default: ;
      endcase
    end
  end

  // live side: period-boundary transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act   <= '1;
      duty_act  <= '0;
      pol_act   <= '0;
      steer_act <= NOUT'(1);
    end else if (wrap) begin
      per_act   <= per_buf;
      duty_act  <= duty_buf;
      pol_act   <= pol_buf;
      steer_act <= steer_buf;
    end
  end

  // dead-band: first of duty match or boundary after a write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_act  <= '0;
      db_pend <= 1'b0;
    end else begin
      if (db_load) db_act <= db_buf;
      if (wr_fire && wr_addr == ADDR_W'(REG_DEADBAND)) db_pend <= 1'b1;
      else if (db_load)                                db_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DB_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw,
  input  logic [DB_W-1:0] db_val,
  output logic            shaped
);
  logic [DB_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!raw)                cnt_q <= '0;
    else if (cnt_q != {DB_W{1'b1}}) cnt_q <= cnt_q + DB_W'(1);
  end

  assign shaped = raw && (cnt_q >= db_val);
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
  parameter int NOUT = 4
) (
  input  logic            shaped,
  input  logic [NOUT-1:0] pol,
  input  logic [NOUT-1:0] steer,
  output logic [NOUT-1:0] pins
);
  for (genvar i = 0; i < NOUT; i++) begin : g_pin
    assign pins[i] = pol[i] ^ (steer[i] & shaped);
  end
endmodule

// File: rtl/dbuf_pwm.sv
module dbuf_pwm
  import dbpwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FINE_W = 2,
  parameter int DB_W   = 7,
  parameter int NOUT   = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int TB_W  = CNT_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        presc_sel,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NOUT-1:0]   pwm_out
);
  logic             wrap, match;
  logic [TB_W-1:0]  tb;
  logic [CNT_W-1:0] per_act;
  logic [TB_W-1:0]  duty_act, duty_buf;
  logic             en_buf;
  logic [NOUT-1:0]  pol_act, steer_act;
  logic [DB_W-1:0]  db_act;
  logic             raw_q, shaped;
  logic             wr_fire;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  pwm_timebase #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel),
    .per_act(per_act), .duty_act(duty_act),
    .wrap(wrap), .match(match), .tb(tb)
  );

  pwm_shadow_regs #(.CNT_W(CNT_W), .FINE_W(FINE_W), .DB_W(DB_W), .NOUT(NOUT),
                    .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .wrap(wrap), .match(match),
    .per_act(per_act), .duty_act(duty_act), .duty_buf(duty_buf),
    .en_buf(en_buf), .pol_act(pol_act), .steer_act(steer_act), .db_act(db_act)
  );

  // raw waveform: set at boundary (not for zero duty), cleared at duty match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     raw_q <= 1'b0;
    else if (wrap)  raw_q <= en_buf && (duty_buf != '0);
    else if (match) raw_q <= 1'b0;
  end

  pwm_deadband #(.DB_W(DB_W)) u_db (
    .clk(clk), .rst_n(rst_n), .raw(raw_q), .db_val(db_act), .shaped(shaped)
  );

  pwm_outstage #(.NOUT(NOUT)) u_out (
    .shaped(shaped), .pol(pol_act), .steer(steer_act), .pins(pwm_out)
  );
endmodule

// File: rtl/dbuf_pwm_chk.sv
module dbuf_pwm_chk #(
  parameter int CNT_W  = 8,
  parameter int FINE_W = 2,
  parameter int DB_W   = 7,
  parameter int NOUT   = 4,
  localparam int TB_W  = CNT_W + FINE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wrap,
  input logic             match,
  input logic [TB_W-1:0]  tb,
  input logic [CNT_W-1:0] per_act,
  input logic [TB_W-1:0]  duty_act,
  input logic [NOUT-1:0]  pol_act,
  input logic [NOUT-1:0]  steer_act,
  input logic [DB_W-1:0]  db_act,
  input logic             raw_q,
  input logic             shaped,
  input logic [NOUT-1:0]  pwm_out
);
  AST_TB_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    tb[TB_W-1:FINE_W] <= per_act);                                     // R2

  AST_ZERO_DUTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> !raw_q);                                      // R4

  AST_FULL_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !wrap && duty_act > {per_act, {FINE_W{1'b1}}}) |=> raw_q); // R5

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(duty_act) && $stable(per_act)
               && $stable(pol_act) && $stable(steer_act)));            // R6

  AST_DEADBAND_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(raw_q) && db_act != '0) |-> !shaped);                       // R10

  AST_DEADBAND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap || match) |=> $stable(db_act));                             // R11

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_out ^ pol_act) & ~steer_act) == '0);                         // R9
endmodule

bind dbuf_pwm dbuf_pwm_chk #(.CNT_W(CNT_W), .FINE_W(FINE_W), .DB_W(DB_W), .NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrap(wrap), .match(match), .tb(tb),
  .per_act(per_act), .duty_act(duty_act), .pol_act(pol_act),
  .steer_act(steer_act), .db_act(db_act), .raw_q(raw_q),
  .shaped(shaped), .pwm_out(pwm_out)
);

// File: tb/sim_dbuf_pwm.sv
`timescale 1ns/1ps
module sim_dbuf_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] presc_sel = 2'd1;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] pwm_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R1";
  bit cmp_en = 1'b0;

  always #5 clk = ~clk;

  dbuf_pwm u0 (
    .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  // behavioural reference model, integer state
  int m_pc, m_tb, m_cnt;
  int per_b, per_a, duty_b, duty_a, db_b, db_a;
  bit en_b, m_r, db_p;
  bit [3:0] pol_b, pol_a, st_b, st_a;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_tb = 0; m_cnt = 0; m_r = 0;
      per_b = 255; per_a = 255; duty_b = 0; duty_a = 0; en_b = 0;
      pol_b = 0; pol_a = 0; st_b = 4'b0001; st_a = 4'b0001;
      db_b = 0; db_a = 0; db_p = 0;
    end else begin
      int dv, ntb, ncnt;
      bit tick, wrp, mat, nr;
      dv   = (presc_sel == 0) ? 1 : (presc_sel == 1) ? 4 : 16;
      tick = (m_pc >= dv - 1);
      wrp  = tick && (m_tb == per_a * 4 + 3);
      ntb  = m_tb; mat = 0;
      if (tick) begin
        ntb = wrp ? 0 : m_tb + 1;
        mat = !wrp && (ntb == duty_a);
      end
      ncnt = m_r ? ((m_cnt < 127) ? m_cnt + 1 : m_cnt) : 0;
      nr = m_r;
      if (wrp) nr = en_b && (duty_b != 0);
      else if (mat) nr = 0;
      if (db_p && (wrp || mat)) begin db_a = db_b; db_p = 0; end
      if (wrp) begin
        per_a = per_b; duty_a = duty_b; pol_a = pol_b; st_a = st_b;
      end
      if (wr_valid) begin
        case (wr_addr)
          3'd0: per_b = wr_data;
          3'd1: duty_b = (wr_data * 4) + (duty_b % 4);
          3'd2: begin duty_b = (duty_b / 4) * 4 + wr_data[1:0]; en_b = wr_data[2]; end
          3'd3: begin pol_b = wr_data[3:0]; st_b = wr_data[7:4]; end
          3'd4: begin db_b = wr_data[6:0]; db_p = 1; end
          default: ;
        endcase
      end
      m_pc = tick ? 0 : m_pc + 1;
      m_tb = ntb; m_r = nr; m_cnt = ncnt;
    end
  end

  function automatic logic [3:0] model_pins();
    logic [3:0] p;
    bit act;
    act = m_r && (m_cnt >= db_a);
    for (int i = 0; i < 4; i++) p[i] = pol_a[i] ^ (st_a[i] & act);
    return p;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      checks++;
      if (pwm_out !== model_pins() || wr_ready !== 1'b1) begin
        fails++;
        $display("FAIL %s (R12 ready) pins actual=%b expected=%b ready=%b", cur_req,
                 pwm_out, model_pins(), wr_ready);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: all requirements, actual cycles=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #2;
    wr_valid = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(posedge clk); #2;
    wr_valid = 1'b0;
  endtask

  task automatic measure(output int per, output int hi);
    logic prev;
    @(negedge clk); prev = pwm_out[0];
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!prev && pwm_out[0]) break;
      prev = pwm_out[0];
    end
    per = 0; hi = 0;
    for (int i = 0; i < 5000; i++) begin
      if (pwm_out[0]) hi++;
      per++;
      prev = pwm_out[0];
      @(negedge clk);
      if (!prev && pwm_out[0]) break;
    end
  endtask

  task automatic count_high(input int n, input int pin, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[pin]) hi++;
    end
  endtask

  initial begin
    int per, hi, bad;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pins", int'(pwm_out), 0);
    chk("R12 ready", int'(wr_ready), 1);
    cmp_en = 1'b1;

    // R7: enable, pins stay idle until the first boundary
    cur_req = "R7";
    wr(0, 4); wr(1, 2); wr(2, 5); wr(3, 8'h10);
    count_high(40, 0, hi);
    chk("R7 idle before boundary", hi, 0);

    // R2 / R3: divide-by-4, period 4, duty 9
    cur_req = "R3";
    measure(per, hi);
    chk("R2 period div4", per, 80);
    chk("R3 active time div4", hi, 36);

    // R6: mid-cycle duty change shows up one boundary later
    cur_req = "R6";
    wr(1, 3);
    measure(per, hi);
    measure(per, hi);
    chk("R6 new duty after boundary", hi, 52);

    cur_req = "R2";
    presc_sel = 2'd0;
    measure(per, hi); measure(per, hi);
    chk("R2 period div1", per, 20);
    chk("R3 active time div1", hi, 13);

    presc_sel = 2'd3;
    wr(0, 1); wr(1, 1);
    measure(per, hi); measure(per, hi);
    chk("R2 period div16", per, 128);
    chk("R3 active time div16", hi, 80);

    presc_sel = 2'd0;
    wr(0, 4);
    measure(per, hi);

    cur_req = "R4";
    wr(1, 0); wr(2, 4);
    repeat (50) @(posedge clk);
    count_high(60, 0, hi);
    chk("R4 zero duty idle", hi, 0);

    cur_req = "R5";
    wr(1, 255); wr(2, 7);
    repeat (50) @(posedge clk);
    count_high(60, 0, hi);
    chk("R5 full duty held", hi, 60);

    cur_req = "R8";
    wr(1, 2); wr(2, 5); wr(3, 8'h3A);
    repeat (50) @(posedge clk);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_out[1] == pwm_out[0]) bad++;
    end
    chk("R8 inverted pin", bad, 0);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_out[3] != 1'b1 || pwm_out[2] != 1'b0) bad++;
    end
    chk("R9 unsteered pins", bad, 0);

    cur_req = "R11";
    wr(3, 8'h10); wr(4, 3);
    measure(per, hi); measure(per, hi);
    cur_req = "R10";
    chk("R10 period kept", per, 20);
    chk("R10 active edge delayed", hi, 6);

    repeat (10) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule